// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a running nanosecond time value for precision-time hardware. On every clock in which counting is enabled it adds a programmable step to the time value. To trim the frequency, it can swap in a second, alternate step once every N enabled clocks. N is programmable, and software writes N minus one.

The time value can be made to fold back through zero at a programmable period. With a period of 2^31 it behaves as a 31-bit count. Software controls the block over a simple register bus with a write port and a separate combinational read port. It can load a new time, restart the count from zero, and take a snapshot of the running value. Software reads the snapshot back at leisure.

Top module: `tc_time_counter`

## Requirements
- R1: After reset every readable register reads 0, the counter is stopped at 0 and the correction phase is 0.
- R2: While the run bit (control bit 0) is 1, the time value grows by the base step on each clock. While the run bit is 0 and no load or restart is written, the value holds.
- R3: With a non-zero correction period P (word address 3), the correction phase counts enabled clocks. On every (P+1)-th enabled clock after a restart, the alternate step is added in place of the base step.
- R4: A correction period of 0 disables correction, so the base step is always used.
- R5: With the fold bit (control bit 1) set, a sum at or above the period (word address 2) has the period subtracted from it. With the fold bit clear, the value wraps modulo 2^CNT_W.
- R6: Writing the control word with the snapshot bit (control bit 3) set latches the time value on the next clock. The latched value is readable at word address 1. The snapshot bit reads 1 for exactly one cycle after the write, then reads 0.
- R7: A write to word address 1 loads the written data into the time value on that clock edge.
- R8: Writing the control word with the restart bit (control bit 2) set clears the time value and the correction phase on that edge. The restart bit always reads 0.
- R9: The register map is control at word 0, time at word 1, period at word 2 and correction period at word 3. The step register is at word 4, with the base step in bits 6:0 and the alternate step in bits 14:8. Written registers read back their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write word address |
| bus_wdata | input | DATA_W | Write data |
| bus_raddr | input | ADDR_W | Read word address |
| bus_rdata | output | DATA_W | Combinational read data |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, 7-bit steps, a 16-bit correction period and a 32-bit bus. A programmable period of 100 puts several fold events within a few clocks. A period of 2^31 and a load just below 2^32 reach the 31-bit fold and the natural wrap in a single step. Small correction periods let alternate-step insertion show up within a dozen clocks, and a restart taken mid-phase shows that the phase is reset.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  // word addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_TIME = 1;
  localparam int unsigned A_PER  = 2;
  localparam int unsigned A_CPER = 3;
  localparam int unsigned A_STEP = 4;
  // control bits
  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_FOLD    = 1;
  localparam int unsigned CTL_RESTART = 2;
  localparam int unsigned CTL_SNAP    = 3;
  localparam int unsigned STEP_ALT_LSB = 8;

  // next time value: add, fold at period, trim to width
  function automatic logic [63:0] next_time(input logic [63:0] cur,
                                            input logic [63:0] step,
                                            input logic [63:0] per,
                                            input logic fold_on,
                                            input int unsigned width);
    logic [63:0] sum;
    logic [63:0] mask;
    sum  = cur + step;
    mask = (width >= 64) ? '1 : ((64'd1 << width) - 64'd1);
    if (fold_on && sum >= per) sum = sum - per;
    return sum & mask;
  endfunction

  function automatic logic folds(input logic [63:0] cur, input logic [63:0] step,
                                 input logic [63:0] per, input logic fold_on);
    return fold_on && ((cur + step) >= per);
  endfunction

  function automatic logic alt_due(input logic [63:0] phase, input logic [63:0] per);
    return (per != 64'd0) && (phase >= per);
  endfunction
endpackage

// File: rtl/tc_regs.sv
`timescale 1ns/1ps
module tc_regs #(
  parameter int CNT_W  = 32,
  parameter int INC_W  = 7,
  parameter int CP_W   = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count_now,
  output logic              run_en,
  output logic              fold_en,
  output logic              snap_fire,
  output logic              restart_pulse,
  output logic              time_load,
  output logic [CNT_W-1:0]  load_value,
  output logic [CNT_W-1:0]  evt_period,
  output logic [CP_W-1:0]   corr_period,
  output logic [INC_W-1:0]  base_step,
  output logic [INC_W-1:0]  alt_step,
  output logic [CNT_W-1:0]  snap_value
);
  import tc_pkg::*;

  logic wr_ctrl;
  assign wr_ctrl       = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign restart_pulse = wr_ctrl && bus_wdata[CTL_RESTART];
  assign time_load     = bus_wr && (bus_addr == ADDR_W'(A_TIME));
  assign load_value    = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en      <= 1'b0;
      fold_en     <= 1'b0;
      snap_fire   <= 1'b0;
      evt_period  <= '0;
      corr_period <= '0;
      base_step   <= '0;
      alt_step    <= '0;
      snap_value  <= '0;
    end else begin
      // snapshot request lives for one cycle only
      snap_fire <= wr_ctrl ? bus_wdata[CTL_SNAP] : 1'b0;
      if (snap_fire) snap_value <= count_now;
      if (wr_ctrl) begin
        run_en  <= bus_wdata[CTL_RUN];
        fold_en <= bus_wdata[CTL_FOLD];
      end
      if (bus_wr && bus_addr == ADDR_W'(A_PER))  evt_period  <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_CPER)) corr_period <= bus_wdata[CP_W-1:0];
      if (bus_wr && bus_addr == ADDR_W'(A_STEP)) begin
        base_step <= bus_wdata[INC_W-1:0];
        alt_step  <= bus_wdata[STEP_ALT_LSB +: INC_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      ADDR_W'(A_CTRL): begin
        bus_rdata[CTL_RUN]  = run_en;
        bus_rdata[CTL_FOLD] = fold_en;
        bus_rdata[CTL_SNAP] = snap_fire;
      end
      ADDR_W'(A_TIME): bus_rdata[CNT_W-1:0] = snap_value;
      ADDR_W'(A_PER):  bus_rdata[CNT_W-1:0] = evt_period;
      ADDR_W'(A_CPER): bus_rdata[CP_W-1:0]  = corr_period;
      ADDR_W'(A_STEP): begin
        bus_rdata[INC_W-1:0]            = base_step;
        bus_rdata[STEP_ALT_LSB +: INC_W] = alt_step;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tc_corr.sv
`timescale 1ns/1ps
module tc_corr #(
  parameter int CP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic            restart_pulse,
  input  logic [CP_W-1:0] corr_period,
  output logic [CP_W-1:0] corr_phase,
  output logic            corr_hit
);
  import tc_pkg::*;

  assign corr_hit = run_en && alt_due(64'(corr_phase), 64'(corr_period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             corr_phase <= '0;
    else if (restart_pulse) corr_phase <= '0;
    else if (run_en)        corr_phase <= corr_hit ? '0 : corr_phase + CP_W'(1);
  end
endmodule

// File: rtl/tc_accum.sv
`timescale 1ns/1ps
module tc_accum #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             fold_en,
  input  logic             restart_pulse,
  input  logic             time_load,
  input  logic [CNT_W-1:0] load_value,
  input  logic [INC_W-1:0] step,
  input  logic [CNT_W-1:0] evt_period,
  output logic [CNT_W-1:0] count_now,
  output logic             fold_hit
);
  import tc_pkg::*;

  logic [63:0] nxt;
  assign nxt      = next_time(64'(count_now), 64'(step), 64'(evt_period), fold_en, CNT_W);
  assign fold_hit = run_en && folds(64'(count_now), 64'(step), 64'(evt_period), fold_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count_now <= '0;
    else if (restart_pulse) count_now <= '0;
    else if (time_load)     count_now <= load_value;
    else if (run_en)        count_now <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/tc_time_counter.sv
`timescale 1ns/1ps
module tc_time_counter #(
  parameter int CNT_W  = 32,
  parameter int INC_W  = 7,
  parameter int CP_W   = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              run_en, fold_en, snap_fire, restart_pulse, time_load;
  logic              corr_hit, fold_hit;
  logic [CNT_W-1:0]  load_value, evt_period, count_now, snap_value;
  logic [CP_W-1:0]   corr_period, corr_phase;
  logic [INC_W-1:0]  base_step, alt_step, step_sel;

  assign step_sel = corr_hit ? alt_step : base_step;

  tc_regs #(.CNT_W(CNT_W), .INC_W(INC_W), .CP_W(CP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .count_now(count_now),
    .run_en(run_en), .fold_en(fold_en), .snap_fire(snap_fire), .restart_pulse(restart_pulse),
    .time_load(time_load), .load_value(load_value), .evt_period(evt_period),
    .corr_period(corr_period), .base_step(base_step), .alt_step(alt_step), .snap_value(snap_value));

  tc_corr #(.CP_W(CP_W)) i_corr (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart_pulse(restart_pulse),
    .corr_period(corr_period), .corr_phase(corr_phase), .corr_hit(corr_hit));

  tc_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .fold_en(fold_en), .restart_pulse(restart_pulse),
    .time_load(time_load), .load_value(load_value), .step(step_sel), .evt_period(evt_period),
    .count_now(count_now), .fold_hit(fold_hit));
endmodule

// File: rtl/tc_time_counter_chk.sv
`timescale 1ns/1ps
module tc_time_counter_chk #(
  parameter int CNT_W = 32,
  parameter int INC_W = 7,
  parameter int CP_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             run_en,
  input logic             fold_en,
  input logic             snap_fire,
  input logic             restart_pulse,
  input logic             time_load,
  input logic             corr_hit,
  input logic [CNT_W-1:0] load_value,
  input logic [CNT_W-1:0] evt_period,
  input logic [CNT_W-1:0] count_now,
  input logic [CNT_W-1:0] snap_value,
  input logic [CP_W-1:0]  corr_period,
  input logic [CP_W-1:0]  corr_phase,
  input logic [INC_W-1:0] step_sel
);
  logic [CNT_W-1:0] step_ext;
  assign step_ext = {{(CNT_W-INC_W){1'b0}}, step_sel};

  p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> (count_now == '0) && (corr_phase == '0));

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !restart_pulse && !time_load) |=> $stable(count_now));

  p_step_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !fold_en && !restart_pulse && !time_load)
      |=> count_now == $past(count_now) + $past(step_ext));

  p_alt_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_period == '0) |-> !corr_hit);

  p_snap_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire |=> snap_value == $past(count_now));

  p_snap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_fire && !bus_wr) |=> !snap_fire);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (time_load && !restart_pulse) |=> count_now == $past(load_value));

  p_fold_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && fold_en && !bus_wr && (count_now < evt_period) && (step_ext < evt_period))
      |=> count_now < $past(evt_period));
endmodule

bind tc_time_counter tc_time_counter_chk #(.CNT_W(CNT_W), .INC_W(INC_W), .CP_W(CP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .run_en(run_en), .fold_en(fold_en),
  .snap_fire(snap_fire), .restart_pulse(restart_pulse), .time_load(time_load),
  .corr_hit(corr_hit), .load_value(load_value), .evt_period(evt_period),
  .count_now(count_now), .snap_value(snap_value), .corr_period(corr_period),
  .corr_phase(corr_phase), .step_sel(step_sel));

// File: tb/test_tc_time_counter.sv
`timescale 1ns/1ps
module test_tc_time_counter;
  localparam int CNT_W = 32, INC_W = 7, CP_W = 16, ADDR_W = 3, DATA_W = 32;
  localparam logic [31:0] RUN = 32'h1, FOLD = 32'h2, RESTART = 32'h4, SNAP = 32'h8;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0, bus_raddr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tc_time_counter #(.CNT_W(CNT_W), .INC_W(INC_W), .CP_W(CP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W))
    i_tc_time_counter (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_raddr = ADDR_W'(a);
    #1 d = bus_rdata;
  endtask

  // run for k idle clocks plus the stopping edge, snapshot, read back
  task automatic measure(input int k, input logic [31:0] fold, output logic [31:0] v);
    wr(0, RUN | fold);
    repeat (k) @(negedge clk);
    wr(0, SNAP | fold);
    @(negedge clk);
    rd(1, v);
  endtask

  // reference: n enabled steps from phase 0
  function automatic logic [31:0] model(input logic [63:0] start, input int n, input int base,
                                        input int alt, input int p, input logic [63:0] per,
                                        input bit fold);
    logic [63:0] v = start;
    for (int i = 1; i <= n; i++) begin
      v = v + ((p != 0 && (i % (p + 1)) == 0) ? 64'(alt) : 64'(base));
      if (fold && v >= per) v = v - per;
      v = v & 64'hFFFF_FFFF;
    end
    return v[31:0];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      check($sformatf("R1 reset word %0d", a), d, 32'h0);
    end
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(2, 32'd100);  rd(2, d); check("R9 period readback", d, 32'd100);
    wr(3, 32'd3);    rd(3, d); check("R9 corr period readback", d, 32'd3);
    wr(4, 32'h0907); rd(4, d); check("R9 step fields", d, 32'h0907);
    wr(0, FOLD | RESTART); rd(0, d); check("R8 restart bit reads 0", d, FOLD);
  endtask

  task automatic t_run_hold;
    logic [31:0] v;
    wr(3, 0); wr(0, 0);
    wr(1, 32'd1000);
    measure(9, 0, v);
    check("R2 base step x10", v, model(1000, 10, 7, 9, 0, 0, 0));
    repeat (5) @(negedge clk);
    wr(0, SNAP); @(negedge clk); rd(1, v);
    check("R2 stopped holds", v, model(1000, 10, 7, 9, 0, 0, 0));
  endtask

  task automatic t_load;
    logic [31:0] v;
    wr(1, 32'd12345);
    wr(0, SNAP); @(negedge clk); rd(1, v);
    check("R7 load while stopped", v, 32'd12345);
  endtask

  task automatic t_corr;
    logic [31:0] v;
    wr(3, 3); wr(0, RESTART);
    measure(10, 0, v);
    check("R3 alt step every 4th clock", v, model(0, 11, 7, 9, 3, 0, 0));
    check("R3 alt step literal", v, 32'd81);
    wr(3, 0); wr(0, RESTART);
    measure(10, 0, v);
    check("R4 zero period no alt", v, 32'd77);
  endtask

  task automatic t_fold;
    logic [31:0] v;
    wr(2, 32'd100); wr(1, 32'd95);
    measure(2, FOLD, v);
    check("R5 fold at 100", v, model(95, 3, 7, 9, 0, 100, 1));
    wr(4, 32'h0905);
    wr(2, 32'h8000_0000); wr(1, 32'h7FFF_FFFD);
    measure(0, FOLD, v);
    check("R5 fold at 2^31", v, 32'd2);
    wr(1, 32'hFFFF_FFFC);
    measure(0, 0, v);
    check("R5 natural wrap", v, 32'd1);
  endtask

  task automatic t_snap_bit;
    logic [31:0] d;
    wr(0, SNAP);
    rd(0, d); check("R6 snap bit set one cycle", d & SNAP, SNAP);
    @(negedge clk);
    rd(0, d); check("R6 snap bit self clears", d & SNAP, 32'h0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(4, 32'h0907); wr(3, 3); wr(0, RESTART);
    wr(1, 32'd500);
    wr(0, RUN); @(negedge clk); @(negedge clk);
    wr(0, RUN | RESTART);
    repeat (4) @(negedge clk);
    wr(0, SNAP); @(negedge clk); rd(1, v);
    check("R8 restart clears time and phase", v, model(0, 5, 7, 9, 3, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_run_hold;
    t_load;
    t_corr;
    t_fold;
    t_snap_bit;
    t_restart;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule